// File: doc/BRIEF.md
# Message FIFO Pointer Controller

This block keeps the bookkeeping for one message FIFO. The FIFO's message slots sit in a shared message RAM. The block holds no message data. It keeps a write index, a read index and an occupancy count. From these it forms a byte address into that RAM, which tells software which slot to touch next.

A direction input makes the FIFO either a transmit queue or a receive queue.

- **Transmit:** software fills the slot at the write index and strobes its increment. The protocol engine strobes its own increment each time it has finished sending the oldest slot.
- **Receive:** the engine strobes its increment after storing a frame. Software reads the slot at the read index and then strobes its increment.

Illegal strobes are dropped and leave a sticky flag behind. The flags stay set until reset or a direction change.

The exported address is `base + index * slot_bytes`, truncated to the address width. Base and slot size are static configuration inputs.

Top module: `msg_fifo_ptr_ctrl`

## Requirements
- R1: After a synchronous reset (`rst`=1 at a clock edge), both indices and the count are 0. `empty`=1, `full`=0, `usr_err`=0 and `ovf`=0.
- R2: With `cfg_tx`=1 (transmit), a legal `usr_inc` advances `head_idx` by one, wrapping from DEPTH-1 to 0, and raises `count` by one. `user_addr` equals `cfg_base + head_idx*cfg_slot_bytes` modulo 2^ADDR_W.
- R3: With `cfg_tx`=1, `hw_inc` advances `tail_idx` by one (same wrap) and lowers `count` by one. When `count` is 0 it has no effect and sets no flag.
- R4: With `cfg_tx`=0 (receive), a legal `hw_inc` advances `head_idx` and raises `count`. `user_addr` equals `cfg_base + tail_idx*cfg_slot_bytes` modulo 2^ADDR_W.
- R5: With `cfg_tx`=0, a legal `usr_inc` advances `tail_idx` and lowers `count`.
- R6: `full` is 1 exactly when `count` equals DEPTH. `empty` is 1 exactly when `count` is 0. `count` never exceeds DEPTH.
- R7: In transmit mode, `usr_inc` while `full` leaves indices and count unchanged. It sets `usr_err`, which stays 1.
- R8: In receive mode, `usr_inc` while `empty` leaves indices and count unchanged. It sets `usr_err`.
- R9: In receive mode, `hw_inc` while `full` drops the store, leaving indices and count unchanged. It sets `ovf`, which stays 1.
- R10: Both strobes may arrive in the same cycle. Each is judged against the count at the start of that cycle, so a legal add and a legal remove together leave `count` unchanged while both indices move.
- R11: In a cycle where `cfg_tx` differs from its value in the previous cycle, both strobes are ignored. At the end of that cycle, indices, count, `usr_err` and `ovf` are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tx | input | 1 | 1 = transmit FIFO, 0 = receive FIFO |
| cfg_base | input | ADDR_W | RAM byte address of slot 0 |
| cfg_slot_bytes | input | SLOT_W | Bytes per message slot |
| usr_inc | input | 1 | Software increment strobe |
| hw_inc | input | 1 | Protocol engine increment strobe |
| user_addr | output | ADDR_W | RAM byte address of the slot for software |
| head_idx | output | IDX_W | Write-side slot index |
| tail_idx | output | IDX_W | Read-side slot index |
| count | output | CNT_W | Occupied slots, 0..DEPTH |
| full | output | 1 | count equals DEPTH |
| empty | output | 1 | count is 0 |
| usr_err | output | 1 | Sticky: software strobe was rejected |
| ovf | output | 1 | Sticky: receive store was dropped while full |

## Verification
The assertions assume that `cfg_tx` is held steady across the reset edge, because the direction register samples it there. They also assume that `cfg_base` and `cfg_slot_bytes` stay static while the pointers move.

The random stimulus changes `cfg_tx` only on rare cycles, never while `rst` is high. It fixes the address configuration for the duration of each phase. Strobes are drawn so that the FIFO spends time both at full and at empty. This drives the rejection paths, the overflow path and the simultaneous-strobe case often.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;

  // Advance a slot index by one, wrapping at the depth.
  function automatic int unsigned next_idx(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Byte address of a slot in the shared message RAM.
  function automatic int unsigned slot_addr(int unsigned base, int unsigned idx,
                                            int unsigned slot_bytes);
    return base + idx * slot_bytes;
  endfunction

endpackage

// File: rtl/mfifo_index.sv
module mfifo_index #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      idx <= '0;
    else if (adv)
      idx <= IDX_W'(mfifo_pkg::next_idx(32'(idx), DEPTH));
  end

  a_r2_index_wraps: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && 32'(idx) == DEPTH - 1) |=> (idx == '0));
endmodule

// File: rtl/mfifo_occupancy.sv
module mfifo_occupancy #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (push_ok && !pop_ok)
      count <= count + 1'b1;
    else if (pop_ok && !push_ok)
      count <= count - 1'b1;
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);
  a_r10_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok && !clr) |=> $stable(count));
  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push_ok && !pop_ok && !clr) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/mfifo_flags.sv
module mfifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tx_mode,
  input  logic usr_inc,
  input  logic hw_inc,
  input  logic full,
  input  logic empty,
  output logic usr_err,
  output logic ovf,
  output logic usr_reject,
  output logic hw_drop
);
  assign usr_reject = !clr && usr_inc && (tx_mode ? full : empty);
  assign hw_drop    = !clr && !tx_mode && hw_inc && full;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      usr_err <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (usr_reject) usr_err <= 1'b1;
      if (hw_drop)    ovf     <= 1'b1;
    end
  end

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (usr_err && !clr) |=> usr_err);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf);
endmodule

// File: rtl/msg_fifo_ptr_ctrl.sv
module msg_fifo_ptr_ctrl #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  parameter int SLOT_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SLOT_W-1:0] cfg_slot_bytes,
  input  logic              usr_inc,
  input  logic              hw_inc,
  output logic [ADDR_W-1:0] user_addr,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              usr_err,
  output logic              ovf
);
  logic cfg_tx_q;
  logic dir_chg;
  logic push_req, pop_req, push_ok, pop_ok;
  logic usr_reject, hw_drop;
  logic [IDX_W-1:0] user_idx;

  always_ff @(posedge clk) cfg_tx_q <= cfg_tx;

  assign dir_chg  = !rst && (cfg_tx != cfg_tx_q);
  // Writer side: software in transmit, engine in receive.
  assign push_req = !dir_chg && (cfg_tx ? usr_inc : hw_inc);
  assign pop_req  = !dir_chg && (cfg_tx ? hw_inc : usr_inc);

  mfifo_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .clr(dir_chg),
    .push_req(push_req), .pop_req(pop_req),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .count(count), .full(full), .empty(empty));

  mfifo_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_head (
    .clk(clk), .rst(rst), .clr(dir_chg), .adv(push_ok), .idx(head_idx));

  mfifo_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tail (
    .clk(clk), .rst(rst), .clr(dir_chg), .adv(pop_ok), .idx(tail_idx));

  mfifo_flags u_flags (
    .clk(clk), .rst(rst), .clr(dir_chg), .tx_mode(cfg_tx),
    .usr_inc(usr_inc), .hw_inc(hw_inc), .full(full), .empty(empty),
    .usr_err(usr_err), .ovf(ovf),
    .usr_reject(usr_reject), .hw_drop(hw_drop));

  assign user_idx  = cfg_tx ? head_idx : tail_idx;
  assign user_addr = ADDR_W'(mfifo_pkg::slot_addr(32'(cfg_base), 32'(user_idx),
                                                  32'(cfg_slot_bytes)));

  a_r11_dir_clears: assert property (@(posedge clk) disable iff (rst)
    dir_chg |=> (count == '0 && head_idx == '0 && tail_idx == '0 && !usr_err && !ovf));
  a_r6_ptr_consistent: assert property (@(posedge clk) disable iff (rst)
    ((32'(tail_idx) + 32'(count)) % DEPTH) == 32'(head_idx));
  a_r7_reject_holds: assert property (@(posedge clk) disable iff (rst)
    (usr_reject && !(cfg_tx ? hw_inc : (hw_inc && !full))) |=> ($stable(head_idx) && $stable(tail_idx)));
  a_r9_drop_holds: assert property (@(posedge clk) disable iff (rst)
    (hw_drop && !usr_inc) |=> ($stable(count) && $stable(head_idx)));
endmodule

// File: tb/tb_msg_fifo_ptr_ctrl.sv
module tb_msg_fifo_ptr_ctrl;
  localparam int DEPTH = 8, ADDR_W = 12, SLOT_W = 8;
  localparam int IDX_W = 3, CNT_W = 4;

  logic clk = 0, rst = 1, cfg_tx = 1, usr_inc = 0, hw_inc = 0;
  logic [ADDR_W-1:0] cfg_base = 12'h100;
  logic [SLOT_W-1:0] cfg_slot_bytes = 8'd16;
  logic [ADDR_W-1:0] user_addr;
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CNT_W-1:0] count;
  logic full, empty, usr_err, ovf;

  int checks = 0, errors = 0;
  int m_head, m_tail, m_cnt, m_err, m_ovf, m_dir;

  always #10 clk = ~clk;

  msg_fifo_ptr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) dut (
    .clk(clk), .rst(rst), .cfg_tx(cfg_tx), .cfg_base(cfg_base),
    .cfg_slot_bytes(cfg_slot_bytes), .usr_inc(usr_inc), .hw_inc(hw_inc),
    .user_addr(user_addr), .head_idx(head_idx), .tail_idx(tail_idx),
    .count(count), .full(full), .empty(empty), .usr_err(usr_err), .ovf(ovf));

  function automatic int wrap_inc(int i);
    return (i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  function automatic int exp_addr(int idx);
    return (int'(cfg_base) + idx * int'(cfg_slot_bytes)) % (1 << ADDR_W);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " head"}, int'(head_idx), m_head);
    chk({tag, " tail"}, int'(tail_idx), m_tail);
    chk({tag, " count"}, int'(count), m_cnt);
    chk("R6 full", int'(full), int'(m_cnt == DEPTH));
    chk("R6 empty", int'(empty), int'(m_cnt == 0));
    chk("R7/R8 usr_err", int'(usr_err), m_err);
    chk("R9 ovf", int'(ovf), m_ovf);
    chk(m_dir ? "R2 user_addr" : "R4 user_addr", int'(user_addr),
        exp_addr(m_dir ? m_head : m_tail));
  endtask

  // Apply one cycle of stimulus (called at a negedge), update the model, check at next negedge.
  task automatic step(int dir, int u, int h, string tag);
    int push, pop, cnt0;
    cfg_tx = dir[0]; usr_inc = u[0]; hw_inc = h[0];
    if (dir != m_dir) begin
      m_head = 0; m_tail = 0; m_cnt = 0; m_err = 0; m_ovf = 0; m_dir = dir;
    end else begin
      cnt0 = m_cnt;
      push = (dir ? u : h) && cnt0 < DEPTH;
      pop  = (dir ? h : u) && cnt0 > 0;
      if (u && (dir ? cnt0 == DEPTH : cnt0 == 0)) m_err = 1;
      if (!dir && h && cnt0 == DEPTH) m_ovf = 1;
      if (push) m_head = wrap_inc(m_head);
      if (pop)  m_tail = wrap_inc(m_tail);
      m_cnt = cnt0 + push - pop;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(int dir);
    cfg_tx = dir[0]; usr_inc = 0; hw_inc = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    m_head = 0; m_tail = 0; m_cnt = 0; m_err = 0; m_ovf = 0; m_dir = dir;
    compare("R1 reset");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1);
    // Transmit: fill past full, then drain past empty.
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, "R2 tx write");
    step(1, 1, 0, "R7 tx write while full");
    step(1, 1, 1, "R7 reject with send");
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, "R3 tx sent");
    step(1, 0, 1, "R3 send while empty");
    step(1, 1, 0, "R2 tx write");
    step(1, 1, 1, "R10 both strobes");
    step(0, 1, 1, "R11 direction change");
    // Receive: store past full, read past empty.
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, "R4/R9 rx store");
    step(0, 1, 1, "R10 read with store at full");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, "R5/R8 rx read");
    step(0, 0, 1, "R4 rx store");
    step(0, 1, 1, "R10 both strobes");
    step(1, 0, 0, "R11 back to transmit");
    // Random phases with different address configurations.
    begin
      int dir = 1;
      void'($urandom(32'd1234));
      for (int ph = 0; ph < 3; ph++) begin
        cfg_base = ADDR_W'($urandom);
        cfg_slot_bytes = SLOT_W'($urandom_range(1, 72));
        do_reset(dir);
        for (int n = 0; n < 3000; n++) begin
          int bias = (n / 150) % 2;
          int u = ($urandom_range(0, 99) < (bias ? 70 : 30)) ? 1 : 0;
          int h = ($urandom_range(0, 99) < (bias ? 30 : 70)) ? 1 : 0;
          if ($urandom_range(0, 199) == 0) dir = 1 - dir;
          step(dir, u, h, "R10 random");
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule